// File: doc/BRIEF.md
# Multiplexed Byte-Wide ROM Read Controller

This block fetches single bytes from a parallel ROM that has an 18-bit byte address but only eight shared address/data lines. The upper sixteen address bits travel over the shared lines in two byte-wide address phases. Two external transparent latches hold them. Each latch closes on the falling edge of a strobe carried by low address pin 1. Address pin 0 selects which latch is open during a strobe. A data phase follows. In it the controller releases the shared lines, drives the two low address bits, enables the ROM through an active-low chip enable and samples the returned byte after a programmable access time.

The host side uses a plain request/acknowledge scheme. When `ready_o` is high, the host raises `req_i` with an address. The host then waits for a single-cycle `done_o`, at which point `data_o` holds the byte. The setup, strobe width, hold and access times are parameters counted in clocks.

Top module: `rom_mux_rd`

## Requirements
- R1: While reset is asserted and in idle, `rom_ce_no`=1, `bus_oe_o`=0, `bus_o`=0, `rom_a1_o`=0, `rom_a0_o`=0, `done_o`=0 and `ready_o`=1.
- R2: The first address phase lasts SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. In it `bus_oe_o`=1, `bus_o`=address bits 9..2, `rom_a0_o`=0 and `rom_ce_no`=1. `rom_a1_o` is high for exactly STROBE_CYC cycles, starting after SETUP_CYC cycles, and is then low for HOLD_CYC cycles.
- R3: The second address phase has the same timing as the first, with `bus_o`=address bits 17..10 and `rom_a0_o`=1.
- R4: The data phase lasts ACCESS_CYC cycles. In it `bus_oe_o`=0, `bus_o`=0, `rom_ce_no`=0, `rom_a1_o`=address bit 1 and `rom_a0_o`=address bit 0. `bus_i` is sampled at the clock edge that ends the phase.
- R5: `done_o` is high for exactly one cycle, 2*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+ACCESS_CYC clock edges after the accepting edge. In that cycle `data_o` equals the ROM byte at the requested address.
- R6: While a read is in progress, `req_i` and `addr_i` have no effect. The returned byte belongs to the accepted address, and exactly one `done_o` pulse is produced.
- R7: In the `done_o` cycle, `rom_ce_no` stays 0 with `rom_a1_o`=0 and the bus released. In the next cycle the outputs return to the R1 idle values.
- R8: Reads at addresses 0x00000 and 0x3FFFF return the correct bytes.
- R9: `ready_o` is high only in idle. A request is accepted only on a clock edge where `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, accepted when ready_o is high |
| addr_i | input | 18 | Byte address for the request |
| ready_o | output | 1 | Controller idle, can accept a request |
| done_o | output | 1 | Single-cycle completion pulse |
| data_o | output | 8 | Byte read from the ROM |
| rom_a0_o | output | 1 | ROM address pin 0; latch select during address phases |
| rom_a1_o | output | 1 | ROM address pin 1; latch strobe during address phases |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| bus_o | output | 8 | Shared bus output value |
| bus_oe_o | output | 1 | Shared bus output enable |
| bus_i | input | 8 | Shared bus input value |

## Verification
Every pin value depends only on how many clock edges have passed since the request was accepted. The bench therefore derives, for each edge count from 0 to LATENCY+1, the expected chip enable, bus enable, both address pins, bus value, done and ready. It compares them at the falling clock edge after that rising edge, so each register on the path has already updated. `done_o` and `data_o` are due exactly 2*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+ACCESS_CYC edges after acceptance. A pulse that comes early or late shows up as a mismatch at the neighbouring counts. The bench models both latches and computes ROM contents arithmetically from the address, so a mis-ordered address phase returns a wrong byte.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_L0_SETUP,
    ST_L0_STROBE,
    ST_L0_HOLD,
    ST_L1_SETUP,
    ST_L1_STROBE,
    ST_L1_HOLD,
    ST_ACCESS,
    ST_FINISH
  } rmr_state_e;

  function automatic rmr_state_e rmr_succ(rmr_state_e s);
    case (s)
      ST_IDLE:      return ST_L0_SETUP;
      ST_L0_SETUP:  return ST_L0_STROBE;
      ST_L0_STROBE: return ST_L0_HOLD;
      ST_L0_HOLD:   return ST_L1_SETUP;
      ST_L1_SETUP:  return ST_L1_STROBE;
      ST_L1_STROBE: return ST_L1_HOLD;
      ST_L1_HOLD:   return ST_ACCESS;
      ST_ACCESS:    return ST_FINISH;
      default:      return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/rmr_seq.sv
module rmr_seq
  import rmr_pkg::*;
#(
  parameter int unsigned AW         = 18,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output rmr_state_e    state_o,
  output logic [AW-1:0] addr_o,
  output logic          sample_o,
  output logic          ready_o
);
  localparam int unsigned MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_CD = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int unsigned MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

  rmr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          idle, adv;

  // cycles spent in a state, minus one
  function automatic logic [CW-1:0] dwell(rmr_state_e s);
    case (s)
      ST_L0_SETUP, ST_L1_SETUP:   return CW'(SETUP_CYC - 1);
      ST_L0_STROBE, ST_L1_STROBE: return CW'(STROBE_CYC - 1);
      ST_L0_HOLD, ST_L1_HOLD:     return CW'(HOLD_CYC - 1);
      ST_ACCESS:                  return CW'(ACCESS_CYC - 1);
      default:                    return '0;
    endcase
  endfunction

  assign idle    = (state_q == ST_IDLE);
  assign adv     = idle ? req_i : (cnt_q == '0);
  assign state_d = adv ? rmr_succ(state_q) : state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (adv)        cnt_q <= dwell(state_d);
      else if (!idle) cnt_q <= cnt_q - 1'b1;
      if (idle && req_i) addr_q <= addr_i;
    end
  end

  assign state_o  = state_q;
  assign addr_o   = addr_q;
  assign sample_o = (state_q == ST_ACCESS) && (cnt_q == '0);
  assign ready_o  = idle;

  a_r6_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(addr_q));
  a_r9_entry_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_L0_SETUP && $past(state_q) != ST_L0_SETUP) |-> $past(state_q) == ST_IDLE);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < MAXC);
endmodule

// File: rtl/rmr_pin_mux.sv
module rmr_pin_mux
  import rmr_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 + 2 * DW
) (
  input  rmr_state_e    state_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          a0_o,
  output logic          a1_o,
  output logic          ce_no
);
  logic [DW-1:0] lo_byte, hi_byte;

  assign lo_byte = addr_i[DW+1:2];
  assign hi_byte = addr_i[AW-1:DW+2];

  always_comb begin
    bus_o    = '0;
    bus_oe_o = 1'b0;
    a0_o     = 1'b0;
    a1_o     = 1'b0;
    ce_no    = 1'b1;
    case (state_i)
      ST_L0_SETUP, ST_L0_STROBE, ST_L0_HOLD: begin
        bus_oe_o = 1'b1;
        bus_o    = lo_byte;
        a1_o     = (state_i == ST_L0_STROBE);
      end
      ST_L1_SETUP, ST_L1_STROBE, ST_L1_HOLD: begin
        bus_oe_o = 1'b1;
        bus_o    = hi_byte;
        a0_o     = 1'b1;
        a1_o     = (state_i == ST_L1_STROBE);
      end
      ST_ACCESS: begin
        ce_no = 1'b0;
        a0_o  = addr_i[0];
        a1_o  = addr_i[1];
      end
      ST_FINISH: ce_no = 1'b0;  // keep latches closed while strobe drops
      default: ;
    endcase
  end
endmodule

// File: rtl/rmr_capture.sv
module rmr_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic [DW-1:0] data_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= sample_i;
      if (sample_i) data_q <= bus_i;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r5_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(data_q));
endmodule

// File: rtl/rom_mux_rd.sv
module rom_mux_rd
  import rmr_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 2,
  localparam int unsigned AW        = 2 + 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          rom_a0_o,
  output logic          rom_a1_o,
  output logic          rom_ce_no,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] bus_i
);
  rmr_state_e    state;
  logic [AW-1:0] addr_q;
  logic          sample;

  rmr_seq #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .state_o(state), .addr_o(addr_q), .sample_o(sample), .ready_o(ready_o)
  );

  rmr_pin_mux #(.DW(DW)) u_mux (
    .state_i(state), .addr_i(addr_q), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .a0_o(rom_a0_o), .a1_o(rom_a1_o), .ce_no(rom_ce_no)
  );

  rmr_capture #(.DW(DW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample), .bus_i(bus_i),
    .data_o(data_o), .done_o(done_o)
  );

  a_r4_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> rom_ce_no);
  a_r2_bus_steady_at_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rom_a1_o) && rom_ce_no) |-> ($stable(bus_o) && bus_oe_o));
  a_r1_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rom_ce_no && !bus_oe_o && !rom_a1_o && !done_o));
  a_r7_ce_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rom_ce_no && !rom_a1_o && !bus_oe_o));
endmodule

// File: tb/tb_rom_mux_rd.sv
module tb_rom_mux_rd;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2 + 2 * DW;
  localparam int S = 2, P = 2, H = 1, A = 3;
  localparam int T = S + P + H;
  localparam int LAT = 2 * T + A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ready, done, a0, a1, ce_n, oe;
  logic [DW-1:0] data, bus_out, bus_in;
  logic [DW-1:0] lat0 = '0, lat1 = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rom_mux_rd #(.DW(DW), .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H), .ACCESS_CYC(A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .ready_o(ready),
    .done_o(done), .data_o(data), .rom_a0_o(a0), .rom_a1_o(a1), .rom_ce_no(ce_n),
    .bus_o(bus_out), .bus_oe_o(oe), .bus_i(bus_in)
  );

  function automatic logic [7:0] rom_byte(logic [17:0] x);
    return x[7:0] ^ {x[12:8], x[15:13]} ^ {2'b00, x[17:16], x[17:16], 2'b00} ^ 8'hA5;
  endfunction

  // external latches close on the falling strobe while the ROM is disabled
  always @(negedge a1) begin
    if (rst_n && ce_n && oe) begin
      if (a0) lat1 <= bus_out;
      else    lat0 <= bus_out;
    end
  end

  assign bus_in = (!ce_n && !oe) ? rom_byte({lat1, lat0, a1, a0}) : 8'hEE;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // {ready, done, ce_n, oe, a1, a0, bus[7:0]}
  function automatic logic [13:0] exp_vec(int p, logic [17:0] x);
    int k, q;
    if (p < 2 * T) begin
      k = (p >= T) ? 1 : 0;
      q = p - k * T;
      return {2'b00, 1'b1, 1'b1, (q >= S && q < S + P), k[0], (k == 1) ? x[17:10] : x[9:2]};
    end else if (p < 2 * T + A) begin
      return {4'b0000, x[1], x[0], 8'h00};
    end else if (p == 2 * T + A) begin
      return {2'b01, 12'h000};
    end
    return {2'b10, 1'b1, 11'h000};
  endfunction

  function automatic string tag_of(int p);
    if (p < T) return "R2";
    if (p < 2 * T) return "R3";
    if (p < 2 * T + A) return "R4";
    if (p == 2 * T + A) return "R5";
    return "R7";
  endfunction

  task automatic do_read(input logic [17:0] x, input bit busy_req, input logic [17:0] alt);
    logic [13:0] act;
    @(negedge clk);
    chk(ready === 1'b1, "R9 ready before request", 32'(ready), 32'd1);
    req = 1'b1;
    addr = x;
    @(negedge clk);
    if (busy_req) addr = alt;  // R6: keep requesting another address
    else begin
      req = 1'b0;
      addr = ~x;
    end
    for (int p = 0; p <= LAT + 1; p++) begin
      act = {ready, done, ce_n, oe, a1, a0, bus_out};
      chk(act === exp_vec(p, x), tag_of(p), 32'(act), 32'(exp_vec(p, x)));
      if (p == LAT) begin
        if (x == 18'h0 || x == 18'h3FFFF)
          chk(data === rom_byte(x), "R8 corner data", 32'(data), 32'(rom_byte(x)));
        else if (busy_req)
          chk(data === rom_byte(x), "R6 data of accepted address", 32'(data), 32'(rom_byte(x)));
        else
          chk(data === rom_byte(x), "R5 data", 32'(data), 32'(rom_byte(x)));
        req = 1'b0;
      end
      if (p <= LAT) @(negedge clk);
    end
  endtask

  initial begin
    logic [17:0] lfsr;
    logic [13:0] act;
    repeat (3) @(negedge clk);
    act = {ready, done, ce_n, oe, a1, a0, bus_out};
    chk(act === {2'b10, 1'b1, 11'h000}, "R1 reset state", 32'(act), 32'h2800);
    rst_n = 1'b1;
    @(negedge clk);
    act = {ready, done, ce_n, oe, a1, a0, bus_out};
    chk(act === {2'b10, 1'b1, 11'h000}, "R1 idle after reset", 32'(act), 32'h2800);

    do_read(18'h00000, 1'b0, '0);  // R8
    do_read(18'h3FFFF, 1'b0, '0);  // R8
    for (int i = 0; i < AW; i++) do_read(18'(1) << i, 1'b0, '0);
    for (int i = 0; i < AW; i++) do_read(~(18'(1) << i), 1'b0, '0);
    lfsr = 18'h2B3C1;
    for (int i = 0; i < 120; i++) begin
      do_read(lfsr, (i % 6) == 0, ~lfsr);
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
    end
    // R6: request held through a whole read yields one pulse only
    do_read(18'h15A5A, 1'b1, 18'h2A5A5);
    repeat (3) begin
      @(negedge clk);
      chk(done === 1'b0 && ce_n === 1'b1, "R6 no extra read", {30'd0, done, ce_n}, 32'd1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule